// File: doc/BRIEF.md
# Radar Chirp Scan Sequencer

This block sets the timing of a pulsed radar receiver. It produces a one-cycle event for each chirp, elevation step and azimuth step, and it runs from one of three event sources. In pass-through mode it forwards externally timed event pulses. In automatic scan it free-runs a programmed chirp schedule. In single-shot mode it runs one chirp for each trigger pulse. Each chirp produced inside the block has up to five phases in a fixed order: long transmit, long listen, guard, short transmit and short listen. Every phase length is a 16-bit cycle count that can be changed at run time. A phase whose count is zero is skipped.

Chirps are counted in three nested levels. The chirp count wraps after a programmable number of chirps per elevation. The elevation count wraps after `ELEV_PER_AZIM` steps. The azimuth count wraps after `AZIM_PER_SCAN` steps, and each azimuth wrap raises a one-cycle scan-complete pulse. The requested mode is adopted only between chirps, so a chirp that has started always runs to its end. The block has no host-side buffering. Its inputs are assumed to be already synchronous to `clk`.

Top module: `radar_scan_sequencer`

## Requirements
- R1: When `rst` is sampled high, the block goes to the following state: no chirp in progress, all event pulses and `scan_done` low, all three counts zero, `long_sel` low, and `scanning` high. `scanning` is high because automatic scan is the mode adopted at reset.
- R2: With `mode_sel` = 2'b01 (automatic scan) held from reset, `chirp_pulse` is high for one cycle in the cycle after the first clock edge without reset. It then repeats every S+1 cycles, where S is the sum of the five phase lengths. The chirp lasts S cycles and is followed by one idle cycle.
- R3: `long_sel` is high for the first (long transmit + long listen) cycles of each chirp and low in the rest of the chirp and while idle.
- R4: A phase length of zero removes that phase from the chirp. When all five lengths are zero, automatic scan gives a chirp pulse in every cycle, and every chirp completes in the cycle it starts.
- R5: When a chirp completes, `chirp_cnt` increments. When it reaches `cfg_chirps_per_elev`, it wraps to 0 instead, and `elev_pulse` fires in the cycle the counts change. A programmed value of 0 acts as 1.
- R6: Each elevation wrap increments `elev_cnt`. After `ELEV_PER_AZIM` steps `elev_cnt` wraps to 0 and `azim_pulse` fires.
- R7: Each azimuth step increments `azim_cnt`. After `AZIM_PER_SCAN` steps `azim_cnt` wraps to 0 and `scan_done` is high for that one cycle.
- R8: With `mode_sel` = 2'b10 (single-shot), a one-cycle `trig` seen while no chirp runs starts one chirp. Its `chirp_pulse` appears in the next cycle. A `trig` that arrives during a chirp is ignored.
- R9: With `mode_sel` = 2'b00 (pass-through), each of `ext_chirp`, `ext_elev` and `ext_azim` is copied to `chirp_pulse`, `elev_pulse` and `azim_pulse` one cycle later. The counts do not change in this mode.
- R10: A change of `mode_sel` has effect only in a cycle where no chirp runs. While a chirp runs, the external event inputs have no effect. `scanning` shows whether the adopted mode is automatic scan. Code 2'b11 is a hold mode that produces no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Requested mode: 00 pass-through, 01 auto scan, 10 single-shot, 11 hold |
| trig | input | 1 | Single-shot start pulse |
| ext_chirp | input | 1 | External chirp event (pass-through) |
| ext_elev | input | 1 | External elevation event (pass-through) |
| ext_azim | input | 1 | External azimuth event (pass-through) |
| cfg_long_tx | input | 16 | Long transmit length in cycles |
| cfg_long_rx | input | 16 | Long listen length in cycles |
| cfg_guard | input | 16 | Guard length in cycles |
| cfg_short_tx | input | 16 | Short transmit length in cycles |
| cfg_short_rx | input | 16 | Short listen length in cycles |
| cfg_chirps_per_elev | input | 6 | Chirps per elevation step |
| long_sel | output | 1 | High during long transmit and long listen |
| chirp_pulse | output | 1 | One-cycle chirp start event |
| elev_pulse | output | 1 | One-cycle elevation step event |
| azim_pulse | output | 1 | One-cycle azimuth step event |
| chirp_cnt | output | 6 | Chirp index within the elevation |
| elev_cnt | output | 6 | Elevation index within the azimuth |
| azim_cnt | output | 6 | Azimuth index within the scan |
| scanning | output | 1 | Adopted mode is automatic scan |
| scan_done | output | 1 | One-cycle pulse on azimuth wrap |

## Verification
The hardest cases to reach are those where a chirp takes zero or one cycle. In those cases a start and a completion fall on the same clock edge, and counts at all three levels can wrap in quick succession. The bench sweeps every combination of the phase lengths 0, 1 and 2 across the five phases, with the chirps-per-elevation value cycling through 0 to 4. It builds the DUT with small elevation and azimuth limits, so that scan-complete wraps happen within a short run. For each run it derives the pulse times, the number of wraps and the final counts arithmetically from S. Directed runs cover a trigger arriving in mid-chirp, and a mode request made during a chirp together with external pulses that arrive while the old chirp is still running.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int DUR_W = 16;
    localparam int NPH   = 5;
    localparam logic [DUR_W-1:0] DUR_ONE = 1;

    typedef enum logic [1:0] {
        MODE_PASS   = 2'b00,
        MODE_AUTO   = 2'b01,
        MODE_SINGLE = 2'b10,
        MODE_HOLD   = 2'b11
    } mode_e;

    // Phase encoding doubles as the order within a chirp.
    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_LONG_TX  = 3'd1,
        PH_LONG_RX  = 3'd2,
        PH_GUARD    = 3'd3,
        PH_SHORT_TX = 3'd4,
        PH_SHORT_RX = 3'd5
    } phase_e;

    typedef logic [NPH-1:0][DUR_W-1:0] dur_set_t;

    typedef struct packed {
        logic chirp;
        logic elev;
        logic azim;
    } evt_t;

    // First phase after cur with a nonzero length, or idle when none is left.
    function automatic phase_e next_phase(input phase_e cur, input dur_set_t d);
        phase_e r;
        r = PH_IDLE;
        for (int k = NPH; k >= 1; k--) begin
            if (k > int'(cur) && d[k-1] != '0) r = phase_e'(k);
        end
        return r;
    endfunction

    function automatic logic [DUR_W-1:0] phase_len(input phase_e p, input dur_set_t d);
        logic [DUR_W-1:0] r;
        r = '0;
        for (int k = 1; k <= NPH; k++) begin
            if (int'(p) == k) r = d[k-1];
        end
        return r;
    endfunction

    function automatic logic is_long(input phase_e p);
        return (p == PH_LONG_TX) || (p == PH_LONG_RX);
    endfunction

endpackage

// File: rtl/scan_phase_seq.sv
module scan_phase_seq
    import scan_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  dur_set_t durs,
    output phase_e   phase,
    output logic     fin
);

    logic [DUR_W-1:0] timer;
    phase_e           first_ph;
    phase_e           after_ph;
    logic             at_end;

    assign first_ph = next_phase(PH_IDLE, durs);
    assign after_ph = next_phase(phase, durs);
    assign at_end   = (phase != PH_IDLE) && (timer == '0);

    // Completion: last cycle of the last nonzero phase, or an empty chirp.
    assign fin = (at_end && after_ph == PH_IDLE) ||
                 (start && phase == PH_IDLE && first_ph == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            timer <= '0;
        end else if (phase == PH_IDLE) begin
            if (start && first_ph != PH_IDLE) begin
                phase <= first_ph;
                timer <= phase_len(first_ph, durs) - DUR_ONE;
            end
        end else if (at_end) begin
            phase <= after_ph;
            if (after_ph != PH_IDLE) timer <= phase_len(after_ph, durs) - DUR_ONE;
        end else begin
            timer <= timer - DUR_ONE;
        end
    end

endmodule

// File: rtl/scan_wrap_ctr.sv
module scan_wrap_ctr #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic [W:0]   limit,
    output logic [W-1:0] count,
    output logic         wrap
);

    localparam logic [W:0] STEP = 1;

    logic [W:0] nxt;

    assign nxt  = {1'b0, count} + STEP;
    assign wrap = inc && (nxt >= limit);

    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (inc) count <= wrap ? '0 : nxt[W-1:0];
    end

endmodule

// File: rtl/radar_scan_sequencer.sv
module radar_scan_sequencer
    import scan_pkg::*;
#(
    parameter int CNT_W         = 6,
    parameter int ELEV_PER_AZIM = 32,
    parameter int AZIM_PER_SCAN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic             trig,
    input  logic             ext_chirp,
    input  logic             ext_elev,
    input  logic             ext_azim,
    input  logic [DUR_W-1:0] cfg_long_tx,
    input  logic [DUR_W-1:0] cfg_long_rx,
    input  logic [DUR_W-1:0] cfg_guard,
    input  logic [DUR_W-1:0] cfg_short_tx,
    input  logic [DUR_W-1:0] cfg_short_rx,
    input  logic [CNT_W-1:0] cfg_chirps_per_elev,
    output logic             long_sel,
    output logic             chirp_pulse,
    output logic             elev_pulse,
    output logic             azim_pulse,
    output logic [CNT_W-1:0] chirp_cnt,
    output logic [CNT_W-1:0] elev_cnt,
    output logic [CNT_W-1:0] azim_cnt,
    output logic             scanning,
    output logic             scan_done
);

    localparam int NLVL = 3;

    dur_set_t durs;
    phase_e   phase;
    mode_e    req_mode;
    mode_e    act_mode;
    logic     idle;
    logic     start;
    logic     fwd;
    logic     seq_fin;
    evt_t     evt_q;
    logic     done_q;

    logic [NLVL-1:0]            lvl_inc;
    logic [NLVL-1:0]            lvl_wrap;
    logic [NLVL-1:0][CNT_W:0]   lvl_lim;
    logic [NLVL-1:0][CNT_W-1:0] lvl_cnt;

    assign durs = {cfg_short_rx, cfg_short_tx, cfg_guard, cfg_long_rx, cfg_long_tx};

    assign req_mode = mode_e'(mode_sel);
    assign idle     = (phase == PH_IDLE);
    assign start    = idle && ((req_mode == MODE_AUTO) ||
                               (req_mode == MODE_SINGLE && trig));
    assign fwd      = idle && (req_mode == MODE_PASS);

    scan_phase_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .durs  (durs),
        .phase (phase),
        .fin   (seq_fin)
    );

    assign lvl_lim[0] = {1'b0, cfg_chirps_per_elev};
    assign lvl_lim[1] = (CNT_W+1)'(ELEV_PER_AZIM);
    assign lvl_lim[2] = (CNT_W+1)'(AZIM_PER_SCAN);

    genvar g;
    generate
        for (g = 0; g < NLVL; g++) begin : g_lvl
            if (g == 0) begin : g_head
                assign lvl_inc[g] = seq_fin;
            end else begin : g_link
                assign lvl_inc[g] = lvl_wrap[g-1];
            end
            scan_wrap_ctr #(.W(CNT_W)) u_ctr (
                .clk   (clk),
                .rst   (rst),
                .inc   (lvl_inc[g]),
                .limit (lvl_lim[g]),
                .count (lvl_cnt[g]),
                .wrap  (lvl_wrap[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            act_mode <= MODE_AUTO;
            evt_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            if (idle) act_mode <= req_mode;
            evt_q.chirp <= start       | (fwd & ext_chirp);
            evt_q.elev  <= lvl_wrap[0] | (fwd & ext_elev);
            evt_q.azim  <= lvl_wrap[1] | (fwd & ext_azim);
            done_q      <= lvl_wrap[2];
        end
    end

    assign long_sel    = is_long(phase);
    assign chirp_pulse = evt_q.chirp;
    assign elev_pulse  = evt_q.elev;
    assign azim_pulse  = evt_q.azim;
    assign chirp_cnt   = lvl_cnt[0];
    assign elev_cnt    = lvl_cnt[1];
    assign azim_cnt    = lvl_cnt[2];
    assign scanning    = (act_mode == MODE_AUTO);
    assign scan_done   = done_q;

endmodule

// File: rtl/scan_seq_checker.sv
module scan_seq_checker
    import scan_pkg::*;
#(
    parameter int CNT_W         = 6,
    parameter int ELEV_PER_AZIM = 32,
    parameter int AZIM_PER_SCAN = 64
) (
    input logic             clk,
    input logic             rst,
    input phase_e           phase,
    input mode_e            act_mode,
    input logic             chirp_pulse,
    input logic             elev_pulse,
    input logic             azim_pulse,
    input logic             scan_done,
    input logic [CNT_W-1:0] chirp_cnt,
    input logic [CNT_W-1:0] elev_cnt,
    input logic [CNT_W-1:0] azim_cnt
);

    a_r5_elev_clears_chirp: assert property (@(posedge clk) disable iff (rst)
        (elev_pulse && act_mode != MODE_PASS) |-> (chirp_cnt == '0));

    a_r6_elev_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(elev_cnt) < ELEV_PER_AZIM);

    a_r7_azim_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(azim_cnt) < AZIM_PER_SCAN);

    a_r7_done_on_azim_wrap: assert property (@(posedge clk) disable iff (rst)
        scan_done |-> (azim_pulse && azim_cnt == '0));

    a_r10_no_event_midchirp: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> !chirp_pulse);

    a_r10_mode_held_in_chirp: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(act_mode));

endmodule

bind radar_scan_sequencer scan_seq_checker #(
    .CNT_W         (CNT_W),
    .ELEV_PER_AZIM (ELEV_PER_AZIM),
    .AZIM_PER_SCAN (AZIM_PER_SCAN)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .phase       (phase),
    .act_mode    (act_mode),
    .chirp_pulse (chirp_pulse),
    .elev_pulse  (elev_pulse),
    .azim_pulse  (azim_pulse),
    .scan_done   (scan_done),
    .chirp_cnt   (chirp_cnt),
    .elev_cnt    (elev_cnt),
    .azim_cnt    (azim_cnt)
);

// File: tb/tb_radar_scan_sequencer.sv
module tb_radar_scan_sequencer;

    localparam int EPA = 2;
    localparam int APS = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'b01;
    logic        trig = 1'b0;
    logic        ext_chirp = 1'b0, ext_elev = 1'b0, ext_azim = 1'b0;
    logic [15:0] cfg_long_tx = '0, cfg_long_rx = '0, cfg_guard = '0;
    logic [15:0] cfg_short_tx = '0, cfg_short_rx = '0;
    logic [5:0]  cfg_cpe = 6'd1;
    logic        long_sel, chirp_pulse, elev_pulse, azim_pulse, scanning, scan_done;
    logic [5:0]  chirp_cnt, elev_cnt, azim_cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    radar_scan_sequencer #(.CNT_W(6), .ELEV_PER_AZIM(EPA), .AZIM_PER_SCAN(APS)) dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .trig(trig),
        .ext_chirp(ext_chirp), .ext_elev(ext_elev), .ext_azim(ext_azim),
        .cfg_long_tx(cfg_long_tx), .cfg_long_rx(cfg_long_rx), .cfg_guard(cfg_guard),
        .cfg_short_tx(cfg_short_tx), .cfg_short_rx(cfg_short_rx),
        .cfg_chirps_per_elev(cfg_cpe),
        .long_sel(long_sel), .chirp_pulse(chirp_pulse), .elev_pulse(elev_pulse),
        .azim_pulse(azim_pulse), .chirp_cnt(chirp_cnt), .elev_cnt(elev_cnt),
        .azim_cnt(azim_cnt), .scanning(scanning), .scan_done(scan_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst = 1'b1; trig = 1'b0;
        ext_chirp = 1'b0; ext_elev = 1'b0; ext_azim = 1'b0;
        mode_sel = m;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_auto(input int a, input int b, input int c, input int d,
                            input int e, input int cpe, input int m);
        int s, p, cp, fins, elevs, azims;
        int t_bad, l_bad, sc_bad, n_el, n_az, n_dn;
        cfg_long_tx = 16'(a); cfg_long_rx = 16'(b); cfg_guard = 16'(c);
        cfg_short_tx = 16'(d); cfg_short_rx = 16'(e); cfg_cpe = 6'(cpe);
        do_reset(2'b01);
        s = a + b + c + d + e;
        p = s + 1;
        cp = (cpe == 0) ? 1 : cpe;
        t_bad = 0; l_bad = 0; sc_bad = 0; n_el = 0; n_az = 0; n_dn = 0;
        for (int cyc = 0; cyc < m; cyc++) begin
            step();
            if (int'(chirp_pulse) != int'(cyc % p == 0)) t_bad++;
            if (int'(long_sel) != int'((cyc % p) < a + b)) l_bad++;
            if (scanning !== 1'b1) sc_bad++;
            n_el += int'(elev_pulse);
            n_az += int'(azim_pulse);
            n_dn += int'(scan_done);
        end
        fins  = (m - 1 >= s) ? ((m - 1 - s) / p + 1) : 0;
        elevs = fins / cp;
        azims = elevs / EPA;
        if (s == 0) chk("R4 chirp pulse every cycle", t_bad, 0);
        else        chk("R2 chirp pulse times", t_bad, 0);
        chk("R3 long select window", l_bad, 0);
        chk("R10 scanning in auto", sc_bad, 0);
        chk("R5 elevation pulses", n_el, elevs);
        chk("R5 final chirp count", int'(chirp_cnt), fins % cp);
        chk("R6 azimuth pulses", n_az, azims);
        chk("R6 final elevation count", int'(elev_cnt), elevs % EPA);
        chk("R7 scan done pulses", n_dn, azims / APS);
        chk("R7 final azimuth count", int'(azim_cnt), azims % APS);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int pulses, sc_bad, p_bad;
        logic pc, pe, pa;

        // R1: reset state, sampled while reset is held
        repeat (3) @(negedge clk);
        chk("R1 chirp_pulse", int'(chirp_pulse), 0);
        chk("R1 elev_pulse", int'(elev_pulse), 0);
        chk("R1 azim_pulse", int'(azim_pulse), 0);
        chk("R1 scan_done", int'(scan_done), 0);
        chk("R1 long_sel", int'(long_sel), 0);
        chk("R1 counts", int'(chirp_cnt) + int'(elev_cnt) + int'(azim_cnt), 0);
        chk("R1 scanning", int'(scanning), 1);

        // R2..R7: sweep of phase lengths 0..2 over all five phases
        for (int i = 0; i < 243; i++) begin
            run_auto(i % 3, (i / 3) % 3, (i / 9) % 3, (i / 27) % 3, (i / 81) % 3, i % 5, 60);
        end
        run_auto(1000, 0, 0, 0, 0, 1, 2100);
        run_auto(3, 0, 7, 0, 2, 3, 400);

        // R8: single-shot with a trigger landing mid-chirp
        cfg_long_tx = 16'd2; cfg_long_rx = 16'd3; cfg_guard = 16'd1;
        cfg_short_tx = 16'd2; cfg_short_rx = 16'd2; cfg_cpe = 6'd4;
        do_reset(2'b10);
        pulses = 0; sc_bad = 0; p_bad = 0;
        for (int cyc = 0; cyc < 40; cyc++) begin
            step();
            pulses += int'(chirp_pulse);
            if (int'(chirp_pulse) != int'(cyc == 3 || cyc == 21)) p_bad++;
            if (scanning !== 1'b0) sc_bad++;
            if (cyc == 5) chk("R8 long_sel during single chirp", int'(long_sel), 1);
            trig = (cyc == 2 || cyc == 6 || cyc == 20);
        end
        chk("R8 single chirp pulse count", pulses, 2);
        chk("R8 single chirp pulse times", p_bad, 0);
        chk("R8 chirp count after two shots", int'(chirp_cnt), 2);
        chk("R10 scanning low in single", sc_bad, 0);

        // R9: pass-through of external events
        do_reset(2'b00);
        pc = 1'b0; pe = 1'b0; pa = 1'b0; p_bad = 0;
        for (int cyc = 0; cyc < 30; cyc++) begin
            step();
            if (chirp_pulse !== pc || elev_pulse !== pe || azim_pulse !== pa) p_bad++;
            pc = (cyc % 3 == 0); pe = (cyc % 5 == 1); pa = (cyc % 7 == 2);
            ext_chirp = pc; ext_elev = pe; ext_azim = pa;
        end
        chk("R9 forwarded pulses", p_bad, 0);
        chk("R9 counts unchanged", int'(chirp_cnt) + int'(elev_cnt) + int'(azim_cnt), 0);
        chk("R9 no scan done", int'(scan_done), 0);

        // R10: mode request during a chirp waits for the boundary
        cfg_long_tx = 16'd5; cfg_long_rx = 16'd5; cfg_guard = 16'd0;
        cfg_short_tx = 16'd5; cfg_short_rx = 16'd5; cfg_cpe = 6'd4;
        do_reset(2'b01);
        pulses = 0;
        for (int cyc = 0; cyc <= 30; cyc++) begin
            step();
            pulses += int'(chirp_pulse);
            if (cyc == 6)  chk("R10 external chirp ignored mid-chirp", int'(chirp_pulse), 0);
            if (cyc == 20) chk("R10 scanning held to boundary", int'(scanning), 1);
            if (cyc == 21) chk("R10 pass adopted at boundary", int'(chirp_pulse), 1);
            if (cyc == 21) chk("R10 scanning after switch", int'(scanning), 0);
            if (cyc == 3) mode_sel = 2'b00;
            ext_chirp = (cyc == 5 || cyc == 20);
        end
        chk("R10 pulse total across switch", pulses, 2);
        chk("R10 chirp count after switch", int'(chirp_cnt), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule